// File: doc/BRIEF.md
# Four-Level Page Walk Permission Checker

The block translates a 48-bit linear address into a physical address by walking four levels of 4 KiB page tables held in memory. A request carries the linear address, an access kind (read, write or instruction fetch), a user-mode flag and a no-execute enable. On a one-cycle start pulse, the walker fetches one 64-bit entry per level through a synchronous read port. The first fetch uses a root table base input, and each later fetch uses the frame address in the previous entry.

Permission is judged over the whole walk and not only over the last entry. The user, writable and no-execute attributes of all visited entries are combined before the final decision. A completed walk gives a one-cycle done pulse with either the physical address or a fault flag and a five-bit error code. On a fault, the offending linear address is kept in a readable fault-address register.

Top module: `ptw_walker`

## Requirements
- R1: After reset, done, fault, mem_rd_en, err_code, phys_addr and fault_addr are all zero.
- R2: The level-k table index (k = 0 for the root) is lin_addr bits [47-9k : 39-9k]. Each entry is read at table base + index*8. The next table base and the final frame come from entry bits [51:12]. phys_addr is that frame joined with lin_addr[11:0].
- R3: A walk that passes every check ends with a single-cycle done pulse, fault = 0, err_code = 0 and the translated phys_addr.
- R4: Entry bit 0 marks the entry present. A clear present bit ends the walk at once with a fault and err_code bit 0 = 0. No further level is read.
- R5: Entry bit 2 allows user access. A user-mode access faults unless bit 2 is set at all four levels. A bit set only in the last entry still gives a fault, with err_code bit 0 = 1.
- R6: Entry bit 1 allows writing. A user-mode write faults unless bit 1 is set at all four levels. Supervisor writes ignore bit 1.
- R7: err_code bit 1 = 1 for a write, bit 2 = 1 for user mode and bit 4 = 1 for an instruction fetch. A user fetch through supervisor-only upper entries gives err_code 0x15. acc_type encodes 0 = read, 1 = write, 2 = fetch.
- R8: A present entry with any of bits [62:52] set, or with bit 63 set while nx_en = 0, ends the walk with a fault. err_code bits 3 and 0 are both 1.
- R9: With nx_en = 1, entry bit 63 at any level makes a fetch fault with err_code bit 0 = 1. Reads through the same entries succeed.
- R10: fault_addr takes lin_addr on every faulting walk and keeps its value across successful walks.
- R11: fault, err_code and phys_addr hold their values from one done pulse until the next walk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, accepted when idle |
| lin_addr | input | 48 | Linear address to translate |
| acc_type | input | 2 | 0 read, 1 write, 2 instruction fetch |
| user_mode | input | 1 | Access is made in user mode |
| nx_en | input | 1 | No-execute checking enabled |
| root_base | input | 52 | Physical base of the root table (bits 11:0 ignored) |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_rd_addr | output | 52 | Entry physical address |
| mem_rd_data | input | 64 | Entry data, valid the cycle after the strobe edge |
| done | output | 1 | Walk-complete pulse |
| fault | output | 1 | Last walk faulted |
| err_code | output | 5 | Encoded fault cause |
| phys_addr | output | 52 | Translated physical address |
| fault_addr | output | 48 | Linear address of the most recent fault |

## Verification
The bench goes after the case where the user bit is set in the last entry but missing above it. A checker that looks only at the last entry would translate that access instead of returning 0x05 or 0x15. Not-present entries at the root and at a middle level are checked by counting reads, which catches a walker that keeps fetching after a missing entry. Supervisor writes through read-only entries must succeed, while user writes through them must fault, so a walker with wrong writable handling is caught either way. Bit 63 is tried with no-execute on (fetch faults, read passes) and off (reserved fault). fault_addr is checked after successful walks to show that it is not overwritten.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENTRY_W = 64;
  localparam int BIT_P   = 0;
  localparam int BIT_W   = 1;
  localparam int BIT_U   = 2;
  localparam int BIT_XD  = 63;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EVAL = 2'd2
  } walk_st_e;
endpackage

// File: rtl/ptw_entry_check.sv
module ptw_entry_check #(
  parameter int PA_W    = 52,
  parameter int PAGE_SH = 12
) (
  input  logic [63:0]              entry,
  input  logic                     nx_en,
  output logic                     present,
  output logic                     writable,
  output logic                     user_ok,
  output logic                     no_exec,
  output logic                     rsvd_hit,
  output logic [PA_W-PAGE_SH-1:0]  frame
);
  import ptw_pkg::*;

  logic unused_bits;
  assign unused_bits = ^entry[PAGE_SH-1:3];

  assign present  = entry[BIT_P];
  assign writable = entry[BIT_W];
  assign user_ok  = entry[BIT_U];
  assign no_exec  = nx_en & entry[BIT_XD];
  assign rsvd_hit = (|entry[62:PA_W]) | (~nx_en & entry[BIT_XD]);
  assign frame    = entry[PA_W-1:PAGE_SH];
endmodule

// File: rtl/ptw_perm_acc.sv
module ptw_perm_acc (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic upd,
  input  logic w_in,
  input  logic u_in,
  input  logic xd_in,
  output logic w_all,
  output logic u_all,
  output logic xd_any
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      w_all  <= 1'b1;
      u_all  <= 1'b1;
      xd_any <= 1'b0;
    end else if (upd) begin
      w_all  <= w_all & w_in;
      u_all  <= u_all & u_in;
      xd_any <= xd_any | xd_in;
    end
  end

  // R5
  u_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!u_all && !clr) |=> !u_all);
  // R9
  xd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (xd_any && !clr) |=> xd_any);
endmodule

// File: rtl/ptw_err_encode.sv
module ptw_err_encode (
  input  logic       prot,
  input  logic       rsvd,
  input  logic       user,
  input  logic [1:0] acc,
  output logic [4:0] code
);
  import ptw_pkg::*;

  always_comb begin
    code[0] = prot;
    code[1] = (acc == ACC_WRITE);
    code[2] = user;
    code[3] = rsvd;
    code[4] = (acc == ACC_FETCH);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int VA_W    = 48,
  parameter int PA_W    = 52,
  parameter int LEVELS  = 4,
  parameter int PAGE_SH = 12,
  parameter int IDX_W   = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VA_W-1:0]  lin_addr,
  input  logic [1:0]       acc_type,
  input  logic             user_mode,
  input  logic             nx_en,
  input  logic [PA_W-1:0]  root_base,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic [63:0]      mem_rd_data,
  output logic             done,
  output logic             fault,
  output logic [4:0]       err_code,
  output logic [PA_W-1:0]  phys_addr,
  output logic [VA_W-1:0]  fault_addr
);
  import ptw_pkg::*;

  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int FRM_W = PA_W - PAGE_SH;
  localparam int SCL_W = PAGE_SH - IDX_W;

  walk_st_e          state;
  logic [LVL_W-1:0]  lvl;
  logic [VA_W-1:0]   lin_q;
  logic [1:0]        acc_q;
  logic              user_q;
  logic              nx_q;

  logic unused_root;
  assign unused_root = ^root_base[PAGE_SH-1:0];

  function automatic logic [IDX_W-1:0] idx_of(input logic [VA_W-1:0] va, input int l);
    logic [VA_W-1:0] s;
    s = va >> (PAGE_SH + IDX_W * (LEVELS - 1 - l));
    return s[IDX_W-1:0];
  endfunction

  logic             e_pres, e_wr, e_usr, e_xd, e_rsvd;
  logic [FRM_W-1:0] e_frame;

  ptw_entry_check #(.PA_W(PA_W), .PAGE_SH(PAGE_SH)) u_echk (
    .entry(mem_rd_data), .nx_en(nx_q),
    .present(e_pres), .writable(e_wr), .user_ok(e_usr),
    .no_exec(e_xd), .rsvd_hit(e_rsvd), .frame(e_frame)
  );

  logic accept, eval, upd;
  logic w_all, u_all, xd_any;
  assign accept = (state == ST_IDLE) && start;
  assign eval   = (state == ST_EVAL);
  assign upd    = eval && e_pres && !e_rsvd;

  ptw_perm_acc u_acc (
    .clk(clk), .rst(rst), .clr(accept), .upd(upd),
    .w_in(e_wr), .u_in(e_usr), .xd_in(e_xd),
    .w_all(w_all), .u_all(u_all), .xd_any(xd_any)
  );

  logic last_lvl, viol, u_fin, w_fin, xd_fin;
  logic [4:0] code_w;
  assign last_lvl = (lvl == LVL_W'(LEVELS - 1));
  assign u_fin    = u_all & e_usr;
  assign w_fin    = w_all & e_wr;
  assign xd_fin   = xd_any | e_xd;
  assign viol     = (user_q & ~u_fin)
                  | (user_q & (acc_q == ACC_WRITE) & ~w_fin)
                  | ((acc_q == ACC_FETCH) & xd_fin);

  ptw_err_encode u_enc (
    .prot(e_pres), .rsvd(e_pres & e_rsvd), .user(user_q),
    .acc(acc_q), .code(code_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      lvl         <= '0;
      lin_q       <= '0;
      acc_q       <= ACC_READ;
      user_q      <= 1'b0;
      nx_q        <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      err_code    <= '0;
      phys_addr   <= '0;
      fault_addr  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          lin_q       <= lin_addr;
          acc_q       <= acc_type;
          user_q      <= user_mode;
          nx_q        <= nx_en;
          lvl         <= '0;
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= {root_base[PA_W-1:PAGE_SH], idx_of(lin_addr, 0), SCL_W'(0)};
          state       <= ST_WAIT;
        end
        ST_WAIT: begin
          mem_rd_en <= 1'b0;
          state     <= ST_EVAL;
        end
        default: begin
          if (!e_pres || e_rsvd || (last_lvl && viol)) begin
            done       <= 1'b1;
            fault      <= 1'b1;
            err_code   <= code_w;
            phys_addr  <= '0;
            fault_addr <= lin_q;
            state      <= ST_IDLE;
          end else if (last_lvl) begin
            done      <= 1'b1;
            fault     <= 1'b0;
            err_code  <= '0;
            phys_addr <= {e_frame, lin_q[PAGE_SH-1:0]};
            state     <= ST_IDLE;
          end else begin
            lvl         <= lvl + 1'b1;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= {e_frame, idx_of(lin_q, int'(lvl) + 1), SCL_W'(0)};
            state       <= ST_WAIT;
          end
        end
      endcase
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  // R2
  idle_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> !mem_rd_en);
  // R8
  rsvd_prot_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err_code[3]) |-> (fault && err_code[0]));
  // R10
  faddr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eval |=> $stable(fault_addr));
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eval |=> ($stable(fault) && $stable(err_code) && $stable(phys_addr)));
endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [47:0] lin_addr = '0;
  logic [1:0]  acc_type = '0;
  logic        user_mode = 1'b0;
  logic        nx_en = 1'b0;
  logic [51:0] root_base = 52'h1000;
  logic        mem_rd_en;
  logic [51:0] mem_rd_addr;
  logic [63:0] mem_rd_data = '0;
  logic        done, fault;
  logic [4:0]  err_code;
  logic [51:0] phys_addr;
  logic [47:0] fault_addr;

  always #10 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst(rst), .start(start), .lin_addr(lin_addr),
    .acc_type(acc_type), .user_mode(user_mode), .nx_en(nx_en),
    .root_base(root_base), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .done(done), .fault(fault),
    .err_code(err_code), .phys_addr(phys_addr), .fault_addr(fault_addr)
  );

  logic [63:0] mem [logic [51:0]];
  always @(posedge clk)
    if (mem_rd_en) mem_rd_data <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 64'h0;

  int rd_cnt = 0;
  always @(posedge clk)
    if (start) rd_cnt <= 0;
    else if (mem_rd_en) rd_cnt <= rd_cnt + 1;

  typedef struct {
    logic        flt;
    logic [4:0]  err;
    logic [51:0] pa;
    logic [47:0] fa;
    int          nrd;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  int checks = 0, fails = 0;
  logic [47:0] last_fa = '0;
  logic [51:0] next_tbl = 52'h10_0000;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Build four dedicated tables for va (distinct top index per test); fN are low flag bits plus bit 63..52
  task automatic map(input logic [47:0] va, input logic [51:0] pa,
                     input logic [63:0] f0, input logic [63:0] f1,
                     input logic [63:0] f2, input logic [63:0] f3);
    logic [51:0] base;
    logic [63:0] fl;
    logic [51:0] nxt;
    base = root_base;
    for (int l = 0; l < 4; l++) begin
      fl = (l == 0) ? f0 : (l == 1) ? f1 : (l == 2) ? f2 : f3;
      if (l == 3) nxt = {pa[51:12], 12'h0};
      else begin nxt = next_tbl; next_tbl = next_tbl + 52'h1000; end
      mem[base + {40'h0, va[47-9*l -: 9], 3'b000}] = {12'h0, nxt} | fl;
      base = nxt;
    end
  endtask

  // Expected result worked out from the requirements
  task automatic model(input logic [47:0] va, input logic [1:0] acc, input logic usr,
                       input logic nx, input string tag);
    exp_t e;
    logic [51:0] base;
    logic [63:0] ent;
    logic u, w, xd, wr, fx;
    bit stop;
    base = root_base; u = 1; w = 1; xd = 0; stop = 0;
    wr = (acc == 2'd1); fx = (acc == 2'd2);
    e.flt = 0; e.err = 0; e.pa = 0; e.nrd = 0; e.tag = tag;
    for (int l = 0; l < 4 && !stop; l++) begin
      logic [51:0] a;
      a = base + {40'h0, va[47-9*l -: 9], 3'b000};
      ent = mem.exists(a) ? mem[a] : 64'h0;
      e.nrd++;
      if (!ent[0]) begin
        e.flt = 1; e.err = {fx, 1'b0, usr, wr, 1'b0}; stop = 1;
      end else if ((|ent[62:52]) || (!nx && ent[63])) begin
        e.flt = 1; e.err = {fx, 1'b1, usr, wr, 1'b1}; stop = 1;
      end else begin
        u &= ent[2]; w &= ent[1]; xd |= (nx & ent[63]);
        base = {ent[51:12], 12'h0};
      end
    end
    if (!stop) begin
      if ((usr && !u) || (usr && wr && !w) || (fx && xd)) begin
        e.flt = 1; e.err = {fx, 1'b0, usr, wr, 1'b1};
      end else e.pa = {base[51:12], va[11:0]};
    end
    if (e.flt) last_fa = va;
    e.fa = last_fa;
    sbq.push_back(e);
  endtask

  task automatic walk(input logic [47:0] va, input logic [1:0] acc, input logic usr,
                      input logic nx, input string tag);
    logic        h_f;
    logic [4:0]  h_e;
    logic [51:0] h_p;
    model(va, acc, usr, nx, tag);
    @(negedge clk);
    lin_addr = va; acc_type = acc; user_mode = usr; nx_en = nx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    h_f = fault; h_e = err_code; h_p = phys_addr;
    repeat (3) @(negedge clk);
    // R11: results hold after the done pulse
    chk(fault == h_f && err_code == h_e && phys_addr == h_p, {"R11 hold ", tag},
        {fault, err_code, phys_addr}, {h_f, h_e, h_p});
  endtask

  // Monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      exp_t e;
      if (sbq.size() == 0) chk(0, "R3 unexpected done", 1, 0);
      else begin
        e = sbq.pop_front();
        chk(fault == e.flt, {"R3 fault ", e.tag}, fault, e.flt);
        chk(err_code == e.err, {"R7 err_code ", e.tag}, err_code, e.err);
        chk(phys_addr == e.pa, {"R2 phys_addr ", e.tag}, phys_addr, e.pa);
        chk(fault_addr == e.fa, {"R10 fault_addr ", e.tag}, fault_addr, e.fa);
        chk(rd_cnt == e.nrd, {"R4 reads ", e.tag}, rd_cnt, e.nrd);
      end
    end
  end

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [63:0] PWU = 64'h7, PW = 64'h3, PU = 64'h5, P = 64'h1;
  localparam logic [63:0] XD = 64'h8000_0000_0000_0000;

  initial begin
    logic [47:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done && !fault && !mem_rd_en && err_code == 0 && phys_addr == 0 && fault_addr == 0,
        "R1 reset", {done, fault, mem_rd_en, err_code}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 R3: supervisor read, full rights
    v = {9'd1, 9'd5, 9'd7, 9'd9, 12'hABC};
    map(v, 52'h12_3456_7000, PWU, PWU, PWU, PWU);
    walk(v, 2'd0, 1'b0, 1'b0, "sup read ok");
    chk(phys_addr == 52'h12_3456_7ABC, "R2 phys literal", phys_addr, 52'h12_3456_7ABC);
    walk(v, 2'd0, 1'b1, 1'b0, "user read ok");
    walk(v, 2'd2, 1'b1, 1'b1, "user fetch ok");

    // R5 R7: user bit only at last level
    v = {9'd2, 9'd1, 9'd2, 9'd3, 12'h006};
    map(v, 52'h9000, PW, PW, PW, PWU);
    walk(v, 2'd2, 1'b1, 1'b0, "user fetch upper supervisor");
    chk(err_code == 5'h15, "R7 code 0x15", err_code, 5'h15);
    walk(v, 2'd0, 1'b1, 1'b0, "user read upper supervisor");
    chk(err_code == 5'h05, "R5 code 0x05", err_code, 5'h05);
    walk(v, 2'd0, 1'b0, 1'b0, "R10 sup read after fault");

    // R4: not present at middle and root level
    v = {9'd3, 9'd4, 9'd4, 9'd4, 12'h010};
    map(v, 52'hA000, PWU, P & 64'h0, PWU, PWU);
    walk(v, 2'd1, 1'b1, 1'b0, "R4 not present lvl1");
    chk(err_code == 5'h06, "R4 code 0x06", err_code, 5'h06);
    v = {9'd200, 9'd0, 9'd0, 9'd0, 12'h0};
    walk(v, 2'd0, 1'b0, 1'b0, "R4 not present root");

    // R6: writable everywhere for user writes; supervisor ignores it
    v = {9'd4, 9'd8, 9'd8, 9'd8, 12'h020};
    map(v, 52'hB000, PWU, PWU, PU, PWU);
    walk(v, 2'd1, 1'b1, 1'b0, "R6 user write ro lvl2");
    chk(err_code == 5'h07, "R6 code 0x07", err_code, 5'h07);
    walk(v, 2'd1, 1'b0, 1'b0, "R6 sup write ro ok");

    // R8: reserved bit in last entry
    v = {9'd5, 9'd9, 9'd9, 9'd9, 12'h030};
    map(v, 52'hC000, PWU, PWU, PWU, PWU | 64'h0080_0000_0000_0000);
    walk(v, 2'd0, 1'b0, 1'b0, "R8 reserved bit 55");
    chk(err_code == 5'h09, "R8 code 0x09", err_code, 5'h09);

    // R9: no-execute bit at root level
    v = {9'd6, 9'd10, 9'd10, 9'd10, 12'h040};
    map(v, 52'hD000, PWU | XD, PWU, PWU, PWU);
    walk(v, 2'd2, 1'b0, 1'b1, "R9 fetch xd");
    chk(err_code == 5'h11, "R9 code 0x11", err_code, 5'h11);
    walk(v, 2'd0, 1'b0, 1'b1, "R9 read xd ok");
    walk(v, 2'd0, 1'b0, 1'b0, "R8 bit63 nx off");

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R3 all results seen", sbq.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule